// File: doc/BRIEF.md
# Synchronous Flow-Through Burst SRAM

This block is a synthesizable behavioural model of a synchronous burst SRAM with 32-bit words and flow-through reads. Every synchronous input (address, write data, the three chip enables, the write controls and the burst controls) is captured on the rising clock edge. A new external address can be loaded by either of two address strobes. The processor-side strobe always starts a read. The controller-side strobe starts a read or a write, depending on the write controls. On the cycles that follow a load, an advance input steps a 2-bit burst counter, and a static mode input selects a linear or an interleaved order within each aligned group of four words.

Reads are flow-through: the word at the address registered on an edge is presented in the cycle that follows that same edge, with no output register. A write stores its data on the edge that samples it, so a read of the same word on the next edge already returns the new data. The pad is modelled as separate input and output buses plus an output-valid flag. An asynchronous active-low output enable blanks the output. An asynchronous active-high sleep input freezes the block in a standby state that keeps its contents. The address width is a parameter: the default gives a small array, and a width of 16 gives the full 64K-word part.

Top module: `burst_sram_ft`

## Requirements
- R1: An edge with procStrobeN low and csLowN low loads addrIn and starts a read. If csAuxN is low and csAuxP is high, the word at addrIn is on rdData with rdValid high in the cycle after that edge.
- R2: procStrobeN is ignored on an edge where csLowN is high. That edge is then decoded as a controller-strobe edge if ctrlStrobeN is low, and as a continuation edge otherwise.
- R3: An edge with ctrlStrobeN low (and no processor load) loads addrIn. It selects the device only if csLowN=0, csAuxN=0 and csAuxP=1, and deselects it otherwise. Chip enables are ignored on edges that load no address. A deselected device neither writes nor raises rdValid.
- R4: allWriteN low on a write-capable edge writes all 32 bits, whatever byteGateN and byteEnN are. rdValid is low in the cycle after a write edge.
- R5: With allWriteN high and byteGateN low, each low byteEnN[i] writes wrData[8i+7:8i] and leaves the other lanes unchanged. With byteGateN high, byteEnN has no effect and the edge is a read.
- R6: An edge that loads through the processor strobe never writes, even with allWriteN low.
- R7: On a continuation edge while selected, advanceN low steps the burst counter by one (modulo 4) and advanceN high holds the address. Write controls on a continuation edge write at the resulting address.
- R8: The low two address bits during a burst are (base + n) mod 4 when linearMode=1 and base XOR n when linearMode=0, where n is the number of advances since the load. The upper address bits stay at the loaded value.
- R9: A word written on one edge is returned by a read on the next edge at the same address, whether that read is a continuation or a new load.
- R10: outEnN high forces rdValid low and rdData to zero at once, without waiting for a clock edge. Lowering it restores the current read word.
- R11: While sleepIn is high, rdValid is low and clock edges change nothing: no writes, no loads and no burst steps. After sleepIn falls, the previous read address is presented again.
- R12: After reset the device is deselected and rdValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low reset of the control state (array not cleared) |
| addrIn | input | ADDR_W | External word address |
| wrData | input | 32 | Write data |
| procStrobeN | input | 1 | Processor-side address strobe, active low, read only |
| ctrlStrobeN | input | 1 | Controller-side address strobe, active low |
| advanceN | input | 1 | Burst advance, active low |
| csLowN | input | 1 | Primary chip enable, active low |
| csAuxN | input | 1 | Second chip enable, active low |
| csAuxP | input | 1 | Third chip enable, active high |
| allWriteN | input | 1 | Global full-word write, active low |
| byteGateN | input | 1 | Gate for the byte enables, active low |
| byteEnN | input | 4 | Per-lane write enables, active low, bit i covers bits 8i+7:8i |
| linearMode | input | 1 | 1 = linear burst order, 0 = interleaved |
| outEnN | input | 1 | Asynchronous output enable, active low |
| sleepIn | input | 1 | Asynchronous standby request, active high |
| rdData | output | 32 | Read word, zero when not valid |
| rdValid | output | 1 | Read word is being driven |

## Verification
The bench targets the edges where two strobes and the chip enables interact. A processor strobe with the primary enable high must fall through to the controller strobe; a design that honoured it would read a word instead of deselecting. Chip enables must be ignored on continuation edges; a design that re-sampled them would drop a read mid-burst or write while deselected. A processor strobe with global write low must not write, and the global write must override a closed byte gate. Bursts are walked through the wrap of both orders, including hold cycles. The checks right after writes catch a missing pass-through or a write to the pre-advance address, and the checks after sleep catch a burst that kept stepping while asleep.

// File: rtl/burst_sram_pkg.sv
`timescale 1ns/1ps
package burst_sram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;

  // strobes from control to datapath for one clock edge
  typedef struct packed {
    logic             loadAddr;
    logic             stepBurst;
    logic [LANES-1:0] wrMask;
  } dpCmd_t;

  function automatic logic [1:0] burstLow(input logic [1:0] base,
                                          input logic [1:0] count,
                                          input logic       linear);
    return linear ? 2'(base + count) : (base ^ count);
  endfunction
endpackage

// File: rtl/burst_sram_array.sv
`timescale 1ns/1ps
module burst_sram_array
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic [LANES-1:0]  wrMask,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdWord
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] laneMem [DEPTH];

    always_ff @(posedge clk) begin
      if (wrMask[g]) laneMem[wrAddr] <= wrData[g*LANE_W +: LANE_W];
    end

    // asynchronous read: flow-through path from the address register
    assign rdWord[g*LANE_W +: LANE_W] = laneMem[rdAddr];
  end
endmodule

// File: rtl/burst_sram_ctrl.sv
`timescale 1ns/1ps
module burst_sram_ctrl
  import burst_sram_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             procStrobeN,
  input  logic             ctrlStrobeN,
  input  logic             advanceN,
  input  logic             csLowN,
  input  logic             csAuxN,
  input  logic             csAuxP,
  input  logic             allWriteN,
  input  logic             byteGateN,
  input  logic [LANES-1:0] byteEnN,
  input  logic             outEnN,
  input  logic             sleepIn,
  output dpCmd_t           cmd,
  output logic             rdValid
);
  logic             selQ;
  logic             readQ;
  logic             procLoad;
  logic             ctrlLoad;
  logic             anyLoad;
  logic             enablesOn;
  logic             selNext;
  logic             awake;
  logic [LANES-1:0] reqMask;

  always_comb begin
    awake     = !sleepIn;
    procLoad  = !procStrobeN && !csLowN;
    ctrlLoad  = !procLoad && !ctrlStrobeN;
    anyLoad   = procLoad || ctrlLoad;
    enablesOn = !csLowN && !csAuxN && csAuxP;
    selNext   = anyLoad ? enablesOn : selQ;

    if (!allWriteN)      reqMask = '1;
    else if (!byteGateN) reqMask = ~byteEnN;
    else                 reqMask = '0;

    cmd.loadAddr  = awake && anyLoad;
    cmd.stepBurst = awake && !anyLoad && selQ && !advanceN;
    cmd.wrMask    = (awake && selNext && !procLoad) ? reqMask : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ  <= 1'b0;
      readQ <= 1'b0;
    end else if (awake) begin
      selQ  <= selNext;
      readQ <= selNext && (procLoad || (reqMask == '0));
    end
  end

  assign rdValid = selQ && readQ && !outEnN && !sleepIn;
endmodule

// File: rtl/burst_sram_dp.sv
`timescale 1ns/1ps
module burst_sram_dp
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              linearMode,
  input  logic              rdValid,
  output logic [DATA_W-1:0] rdData
);
  logic [ADDR_W-1:0] baseQ;
  logic [1:0]        cntQ;
  logic [ADDR_W-1:0] baseNext;
  logic [1:0]        cntNext;
  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] effAddr;
  logic [DATA_W-1:0] rdWord;

  always_comb begin
    baseNext = cmd.loadAddr ? addrIn : baseQ;
    if (cmd.loadAddr)       cntNext = 2'd0;
    else if (cmd.stepBurst) cntNext = 2'(cntQ + 2'd1);
    else                    cntNext = cntQ;
    effAddr = {baseNext[ADDR_W-1:2], burstLow(baseNext[1:0], cntNext, linearMode)};
    curAddr = {baseQ[ADDR_W-1:2], burstLow(baseQ[1:0], cntQ, linearMode)};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ <= '0;
      cntQ  <= 2'd0;
    end else begin
      baseQ <= baseNext;
      cntQ  <= cntNext;
    end
  end

  burst_sram_array #(.ADDR_W(ADDR_W)) u_array (
    .clk    (clk),
    .wrMask (cmd.wrMask),
    .wrAddr (effAddr),
    .wrData (wrData),
    .rdAddr (curAddr),
    .rdWord (rdWord)
  );

  assign rdData = rdValid ? rdWord : '0;
endmodule

// File: rtl/burst_sram_ft.sv
`timescale 1ns/1ps
module burst_sram_ft
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [31:0]       wrData,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              advanceN,
  input  logic              csLowN,
  input  logic              csAuxN,
  input  logic              csAuxP,
  input  logic              allWriteN,
  input  logic              byteGateN,
  input  logic [3:0]        byteEnN,
  input  logic              linearMode,
  input  logic              outEnN,
  input  logic              sleepIn,
  output logic [31:0]       rdData,
  output logic              rdValid
);
  dpCmd_t cmd;

  burst_sram_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .procStrobeN (procStrobeN),
    .ctrlStrobeN (ctrlStrobeN),
    .advanceN    (advanceN),
    .csLowN      (csLowN),
    .csAuxN      (csAuxN),
    .csAuxP      (csAuxP),
    .allWriteN   (allWriteN),
    .byteGateN   (byteGateN),
    .byteEnN     (byteEnN),
    .outEnN      (outEnN),
    .sleepIn     (sleepIn),
    .cmd         (cmd),
    .rdValid     (rdValid)
  );

  burst_sram_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (cmd),
    .addrIn     (addrIn),
    .wrData     (wrData),
    .linearMode (linearMode),
    .rdValid    (rdValid),
    .rdData     (rdData)
  );
endmodule

// File: rtl/burst_sram_chk.sv
`timescale 1ns/1ps
module burst_sram_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addrIn,
  input logic [31:0]       wrData,
  input logic              procStrobeN,
  input logic              ctrlStrobeN,
  input logic              csLowN,
  input logic              csAuxN,
  input logic              csAuxP,
  input logic              allWriteN,
  input logic              outEnN,
  input logic              sleepIn,
  input logic [31:0]       rdData,
  input logic              rdValid
);
  // R1: selected processor load yields a driven read on the next cycle
  assert_proc_read_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!procStrobeN && !csLowN && !csAuxN && csAuxP && !sleepIn)
    |=> (outEnN || sleepIn || rdValid));

  // R3: controller load with the high-active enable off deselects
  assert_deselect_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlStrobeN && (procStrobeN || csLowN) && !csAuxP && !sleepIn)
    |=> !rdValid);

  // R4: a selected global write leaves the output undriven next cycle
  assert_write_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlStrobeN && procStrobeN && !csLowN && !csAuxN && csAuxP &&
     !allWriteN && !sleepIn)
    |=> !rdValid);

  // R9: full write followed by a processor read of the same word
  assert_pass_through_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((!ctrlStrobeN && procStrobeN && !csLowN && !csAuxN && csAuxP &&
      !allWriteN && !sleepIn)
     ##1 (!procStrobeN && !csLowN && !csAuxN && csAuxP && !sleepIn &&
          addrIn == $past(addrIn)))
    |=> (outEnN || sleepIn || rdData == $past(wrData, 2)));

  // R10: output enable high blanks the output
  assert_oe_blank_R10: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> (!rdValid && rdData == 32'd0));

  // R11: sleep keeps the output invalid
  assert_sleep_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    sleepIn |-> !rdValid);
endmodule

bind burst_sram_ft burst_sram_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/burst_sram_ft_tb_top.sv
`timescale 1ns/1ps
module burst_sram_ft_tb_top;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rstN;
  logic [AW-1:0] addrIn;
  logic [31:0]   wrData;
  logic          procStrobeN, ctrlStrobeN, advanceN;
  logic          csLowN, csAuxN, csAuxP;
  logic          allWriteN, byteGateN;
  logic [3:0]    byteEnN;
  logic          linearMode, outEnN, sleepIn;
  logic [31:0]   rdData;
  logic          rdValid;

  int  compared   = 0;
  int  mismatched = 0;
  bit  done       = 1'b0;
  logic [31:0] shadow [1 << AW];

  always #2.5 clk = ~clk;

  burst_sram_ft #(.ADDR_W(AW)) dut_i (.*);

  localparam logic [1:0] K_WFULL = 2'd0;
  localparam logic [1:0] K_WBYTE = 2'd1;
  localparam logic [1:0] K_READ  = 2'd2;

  typedef struct packed {
    logic [1:0]    kind;
    logic [AW-1:0] addr;
    logic [3:0]    benN;
    logic [31:0]   data;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{K_WFULL, 10'd8,    4'hF, 32'h1111_0008},
    '{K_WFULL, 10'd9,    4'hF, 32'h2222_0009},
    '{K_WFULL, 10'd10,   4'hF, 32'h3333_000A},
    '{K_WFULL, 10'd11,   4'hF, 32'h4444_000B},
    '{K_WFULL, 10'd20,   4'hF, 32'hDEAD_BEEF},
    '{K_WBYTE, 10'd20,   4'b0110, 32'h0123_4567},
    '{K_READ,  10'd8,    4'hF, 32'h0},
    '{K_READ,  10'd11,   4'hF, 32'h0},
    '{K_READ,  10'd20,   4'hF, 32'h0},
    '{K_WFULL, 10'd1023, 4'hF, 32'hCAFE_F00D},
    '{K_READ,  10'd1023, 4'hF, 32'h0},
    '{K_READ,  10'd9,    4'hF, 32'h0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    procStrobeN = 1'b1; ctrlStrobeN = 1'b1; advanceN = 1'b1;
    allWriteN = 1'b1; byteGateN = 1'b1; byteEnN = 4'hF;
    csLowN = 1'b0; csAuxN = 1'b0; csAuxP = 1'b1;
  endtask

  task automatic procRead(input logic [AW-1:0] a);
    idle(); procStrobeN = 1'b0; addrIn = a;
    tick(); idle();
  endtask

  task automatic ctrlWriteFull(input logic [AW-1:0] a, input logic [31:0] d);
    idle(); ctrlStrobeN = 1'b0; allWriteN = 1'b0; addrIn = a; wrData = d;
    shadow[a] = d;
    tick(); idle();
  endtask

  task automatic expectRead(input string tag, input logic [AW-1:0] a);
    check({tag, " valid"}, {31'd0, rdValid}, 32'd1);
    check({tag, " data"}, rdData, shadow[a]);
  endtask

  task automatic advStep(input string tag, input logic [AW-1:0] a);
    idle(); advanceN = 1'b0; tick(); idle();
    expectRead(tag, a);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; addrIn = '0; wrData = '0; idle();
    linearMode = 1'b1; outEnN = 1'b0; sleepIn = 1'b0;
    repeat (3) tick();
    check("R12 reset valid", {31'd0, rdValid}, 32'd0);
    rstN = 1'b1;
    tick();
    check("R12 deselected after reset", {31'd0, rdValid}, 32'd0);

    // table walk: writes (R4, R5) and processor reads (R1)
    foreach (VECS[i]) begin
      idle();
      addrIn = VECS[i].addr;
      wrData = VECS[i].data;
      case (VECS[i].kind)
        K_WFULL: begin
          ctrlStrobeN = 1'b0; allWriteN = 1'b0;
          shadow[VECS[i].addr] = VECS[i].data;
        end
        K_WBYTE: begin
          ctrlStrobeN = 1'b0; byteGateN = 1'b0; byteEnN = VECS[i].benN;
          for (int b = 0; b < 4; b++)
            if (!VECS[i].benN[b])
              shadow[VECS[i].addr][b*8 +: 8] = VECS[i].data[b*8 +: 8];
        end
        default: procStrobeN = 1'b0;
      endcase
      tick();
      if (VECS[i].kind == K_READ) expectRead("R1 table read", VECS[i].addr);
      else check("R4 R5 table write leaves output idle", {31'd0, rdValid}, 32'd0);
    end
    idle();
    check("R5 byte lanes 0 and 3 merged", shadow[20], 32'h01AD_BE67);

    // pass-through on continuation, with hold (R9, R7)
    ctrlWriteFull(10'd30, 32'h5A5A_1234);
    check("R4 write cycle output idle", {31'd0, rdValid}, 32'd0);
    tick();
    expectRead("R9 pass-through continuation", 10'd30);

    // pass-through on a fresh processor load (R9)
    ctrlWriteFull(10'd31, 32'h7777_8888);
    procRead(10'd31);
    expectRead("R9 pass-through new load", 10'd31);

    // processor strobe never writes (R6)
    idle(); procStrobeN = 1'b0; allWriteN = 1'b0; addrIn = 10'd31; wrData = 32'h0;
    tick(); idle();
    expectRead("R6 proc strobe with write", 10'd31);
    tick();
    expectRead("R6 word kept", 10'd31);

    // byte gate high: byte enables ignored (R5)
    idle(); ctrlStrobeN = 1'b0; byteGateN = 1'b1; byteEnN = 4'h0;
    addrIn = 10'd31; wrData = 32'hFFFF_FFFF;
    tick(); idle();
    expectRead("R5 gate closed reads", 10'd31);

    // global write overrides closed gate (R4)
    idle(); ctrlStrobeN = 1'b0; allWriteN = 1'b0; byteGateN = 1'b1; byteEnN = 4'hF;
    addrIn = 10'd31; wrData = 32'h0BAD_F00D; shadow[31] = 32'h0BAD_F00D;
    tick(); idle();
    tick();
    expectRead("R4 global write", 10'd31);

    // processor strobe ignored with primary enable high (R2)
    idle(); procStrobeN = 1'b0; csLowN = 1'b1; addrIn = 10'd8;
    tick(); idle();
    expectRead("R2 ignored proc strobe", 10'd31);
    idle(); procStrobeN = 1'b0; ctrlStrobeN = 1'b0; csLowN = 1'b1; addrIn = 10'd9;
    tick(); idle();
    check("R2 ctrl strobe took edge and deselected", {31'd0, rdValid}, 32'd0);

    // deselected: continuation write ignored, enables not sampled (R3)
    idle(); allWriteN = 1'b0; wrData = 32'h0; addrIn = 10'd31;
    tick(); idle();
    check("R3 deselected stays idle", {31'd0, rdValid}, 32'd0);
    procRead(10'd31);
    expectRead("R3 no write while deselected", 10'd31);
    procRead(10'd9);
    expectRead("R3 check word 9 kept", 10'd9);
    idle(); ctrlStrobeN = 1'b0; csAuxN = 1'b1; addrIn = 10'd8;
    tick(); idle();
    check("R3 ctrl load with csAuxN high deselects", {31'd0, rdValid}, 32'd0);
    procRead(10'd8);
    idle(); csAuxN = 1'b1; csAuxP = 1'b0;
    tick(); idle();
    expectRead("R3 enables ignored on continuation", 10'd8);

    // linear burst from base 10: 10,11,8,(hold)8,9,10 (R7, R8)
    linearMode = 1'b1;
    procRead(10'd10);
    expectRead("R8 linear n0", 10'd10);
    advStep("R8 linear n1", 10'd11);
    advStep("R8 linear n2 wraps", 10'd8);
    tick();
    expectRead("R7 hold", 10'd8);
    advStep("R8 linear n3", 10'd9);
    advStep("R7 counter wraps to base", 10'd10);

    // interleaved burst from base 9: 9,8,11,10,9 (R8)
    linearMode = 1'b0;
    procRead(10'd9);
    expectRead("R8 interleaved n0", 10'd9);
    advStep("R8 interleaved n1", 10'd8);
    advStep("R8 interleaved n2", 10'd11);
    advStep("R8 interleaved n3", 10'd10);
    advStep("R8 interleaved wraps", 10'd9);

    // burst write at advanced addresses (R7)
    linearMode = 1'b1;
    ctrlWriteFull(10'd40, 32'hAAAA_0040);
    idle(); advanceN = 1'b0; allWriteN = 1'b0; wrData = 32'hAAAA_0041; shadow[41] = wrData;
    tick();
    wrData = 32'hAAAA_0042; shadow[42] = wrData;
    tick(); idle();
    procRead(10'd40);
    expectRead("R7 burst write w0", 10'd40);
    advStep("R7 burst write w1", 10'd41);
    advStep("R7 burst write w2", 10'd42);

    // asynchronous output enable (R10)
    outEnN = 1'b1; #1;
    check("R10 oe high valid", {31'd0, rdValid}, 32'd0);
    check("R10 oe high data", rdData, 32'd0);
    outEnN = 1'b0; #1;
    expectRead("R10 oe restored", 10'd42);

    // sleep freezes state (R11)
    tick();
    procRead(10'd8);
    expectRead("R11 before sleep", 10'd8);
    sleepIn = 1'b1; advanceN = 1'b0; allWriteN = 1'b0; wrData = 32'h0;
    procStrobeN = 1'b0; addrIn = 10'd11;
    tick();
    check("R11 asleep valid", {31'd0, rdValid}, 32'd0);
    tick();
    check("R11 still asleep", {31'd0, rdValid}, 32'd0);
    idle(); sleepIn = 1'b0; #1;
    expectRead("R11 address and word held", 10'd8);
    tick();
    advStep("R11 burst resumes", 10'd9);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule